// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

A single-port synchronous static RAM with a late-write protocol. On every rising clock edge the block registers one operation: a read, a write, or a deselected cycle. For a write, only the address and the byte-lane mask are taken at that edge. The data for the write is sampled on the following rising edge and stored in the array at that same edge. A read launches its data on the falling edge in the middle of the cycle in which the read was registered. An asynchronous output enable gates the drive of the data bus. A sleep input stops the block from accepting new operations while leaving the array contents intact.

A word is made of `LANES` byte lanes of `LANE_W` bits each. The default is four 9-bit lanes, which gives a 36-bit word. Setting `LANES` to 2 gives an 18-bit organisation. Each lane has its own write enable. The data bus is split into an input `din`, an output `dq` and a pad enable `dq_drv`. The pad cell turns `dq_drv` into the tri-state control. When `dq_drv` is low, the bus is meant to be released, that is, in high impedance.

The control is a four-state machine, where each state records what the last rising edge registered:
- `ST_IDLE`: deselected, or just out of reset.
- `ST_READ`: a read was registered.
- `ST_WPEND`: a write was registered and its data is due at the next edge.
- `ST_SLEEP`: sleep was seen.

Every edge takes one of the following transitions, chosen by priority from any state:
- *doze* to `ST_SLEEP` when `sleep` is high.
- *accept-write* to `ST_WPEND` when `sel` and `wr` are high.
- *accept-read* to `ST_READ` when `sel` is high and `wr` is low.
- *deselect* to `ST_IDLE` otherwise.

Reset also enters `ST_IDLE`. When the block leaves `ST_WPEND`, whatever the transition, the pending write is committed at that edge.

Top module: `lw_sram`

## Requirements
- R1: While reset is asserted and after it is released, `dq_drv` is low until a read is registered.
- R2: A write registered at rising edge k stores the value on `din` at edge k+1, at the address and under the lane mask registered at edge k. A later read of that address returns the stored value.
- R3: The data for a read registered at rising edge k appears on `dq`, with `dq_drv` high, after the falling edge that follows edge k. Before that falling edge, `dq` still holds the previous read result.
- R4: Bit i of `byte_en` enables lane i, which is `din[9i+8:9i]` at the default lane width. Lanes whose bit is low keep their old contents.
- R5: Writes on consecutive edges are supported. Each edge commits the previous write's data and registers the next write.
- R6: A read registered at the edge where the previous write's data arrives, to the same address, returns the new data.
- R7: While `sleep` is high at a rising edge, the operation presented at that edge is ignored. No write is registered and no read drives the bus.
- R8: The bus is not driven in a cycle that registered a write or a deselect, whatever the state of `oe`.
- R9: `oe` acts asynchronously. Lowering it drops `dq_drv` with no clock edge, and raising it within a read's output window restores `dq_drv`.
- R10: A write pending when `sleep` rises is still committed. After `sleep` falls, the array contents are intact and operations are accepted from the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Operations are registered on the rising edge and read data launches on the falling edge. |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Synchronous select, active high |
| wr | input | 1 | 1 = write, 0 = read, when selected |
| byte_en | input | LANES | Per-lane write enable |
| addr | input | $clog2(DEPTH) | Word address |
| din | input | LANES*LANE_W | Write data, sampled one edge after its write |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Low-power request, blocks new operations |
| dq | output | LANES*LANE_W | Read data |
| dq_drv | output | 1 | Bus drive enable for the pad. Low means high impedance. |

## Verification
Two kinds of internal error show at the ports quickly:
- A wrong state shows at the next falling edge. A missed `ST_READ` leaves `dq_drv` low, and a spurious one drives the bus in a write or deselect cycle.
- A lost or misaddressed pending write stays invisible until the address is read back. Because of that, every write in the tests is followed by a read within a few cycles, including the read that shares the data edge.

Lane-mask errors show as a single corrupted 9-bit field on that read-back. The bench also samples `dq` just after the rising edge to catch data that launches half a cycle early.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WPEND = 2'd2,
        ST_SLEEP = 2'd3
    } lw_state_e;
endpackage

// File: rtl/lw_ctrl.sv
module lw_ctrl
    import lw_sram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic [LANES-1:0] byte_en,
    input  logic [AW-1:0]    addr,
    input  logic             sleep,
    output lw_state_e        state_q,
    output logic [AW-1:0]    op_addr_q,
    output logic [LANES-1:0] mask_q,
    output logic             commit_en,
    output logic             rd_cycle
);
    lw_state_e state_nx;

    // transition choice, priority: doze, accept-write, accept-read, deselect
    always_comb begin
        if (sleep)
            state_nx = ST_SLEEP;
        else if (sel && wr)
            state_nx = ST_WPEND;
        else if (sel)
            state_nx = ST_READ;
        else
            state_nx = ST_IDLE;
    end

    // state register; one address register serves both the read and the pending write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_addr_q <= '0;
            mask_q    <= '0;
        end else begin
            state_q <= state_nx;
            if (!sleep) begin
                op_addr_q <= addr;
                mask_q    <= byte_en;
            end
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        commit_en = 1'b0;
        rd_cycle  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_READ:  rd_cycle  = 1'b1;
            ST_WPEND: commit_en = 1'b1;
            ST_SLEEP: ;
            default:  ;
        endcase
    end

    p_write_pends_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && !sleep) |=> (state_q == ST_WPEND));

    p_sleep_blocks_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (!commit_en && !rd_cycle));
endmodule

// File: rtl/lw_array.sv
module lw_array #(
    parameter int DEPTH  = 64,
    parameter int AW     = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int W     = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             we,
    input  logic [LANES-1:0] wmask,
    input  logic [AW-1:0]    waddr,
    input  logic [W-1:0]     wdata,
    input  logic [AW-1:0]    raddr,
    output logic [W-1:0]     rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[g])
                lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
    end
endmodule

// File: rtl/lw_rdport.sv
module lw_rdport #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_cycle,
    input  logic [W-1:0] rdata,
    input  logic         oe,
    output logic [W-1:0] dq,
    output logic         dq_drv
);
    logic         rd_valid;
    logic [W-1:0] q_r;

    // read data launches on the falling edge of the cycle that registered the read
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            q_r      <= '0;
        end else begin
            rd_valid <= rd_cycle;
            if (rd_cycle)
                q_r <= rdata;
        end
    end

    assign dq     = q_r;
    assign dq_drv = oe && rd_valid;
endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    parameter int DEPTH  = 64,
    localparam int W     = LANE_W * LANES,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic [LANES-1:0] byte_en,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     din,
    input  logic             oe,
    input  logic             sleep,
    output logic [W-1:0]     dq,
    output logic             dq_drv
);
    lw_state_e        state_q;
    logic [AW-1:0]    op_addr_q;
    logic [LANES-1:0] mask_q;
    logic             commit_en;
    logic             rd_cycle;
    logic [W-1:0]     rdata;

    lw_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .byte_en(byte_en),
        .addr(addr), .sleep(sleep), .state_q(state_q), .op_addr_q(op_addr_q),
        .mask_q(mask_q), .commit_en(commit_en), .rd_cycle(rd_cycle)
    );

    lw_array #(.DEPTH(DEPTH), .AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk(clk), .we(commit_en), .wmask(mask_q), .waddr(op_addr_q),
        .wdata(din), .raddr(op_addr_q), .rdata(rdata)
    );

    lw_rdport #(.W(W)) u_rdport (
        .clk(clk), .rst_n(rst_n), .rd_cycle(rd_cycle), .rdata(rdata),
        .oe(oe), .dq(dq), .dq_drv(dq_drv)
    );

    p_drive_after_read_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        dq_drv |-> $past(sel && !wr && !sleep));

    p_sleep_no_drive_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep) |-> !dq_drv);
endmodule

// File: tb/test_lw_sram.sv
`timescale 1ns/100ps
module test_lw_sram;
    localparam int LW = 9;
    localparam int LN = 4;
    localparam int DP = 64;
    localparam int W  = LW * LN;
    localparam int AW = $clog2(DP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0, wr = 1'b0, oe = 1'b1, sleep = 1'b0;
    logic [LN-1:0] byte_en = '0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  din = '0;
    logic [W-1:0]  dq;
    logic          dq_drv;

    int n_vec = 0;
    int n_bad = 0;

    logic [W-1:0]  model [DP];
    logic          m_pend = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [LN-1:0] m_mask = '0;
    logic [W-1:0]  last_rd = '0;

    always #2 clk = ~clk;

    lw_sram #(.LANE_W(LW), .LANES(LN), .DEPTH(DP)) i_lw_sram (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .byte_en(byte_en),
        .addr(addr), .din(din), .oe(oe), .sleep(sleep), .dq(dq), .dq_drv(dq_drv)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle: d is the data for the previously registered write
    task automatic op(input logic s, input logic w, input logic [LN-1:0] be,
                      input logic [AW-1:0] a, input logic [W-1:0] d,
                      input logic zz, input string tag);
        logic rd;
        sel = s; wr = w; byte_en = be; addr = a; din = d; sleep = zz;
        @(posedge clk);
        if (m_pend)
            for (int i = 0; i < LN; i++)
                if (m_mask[i]) model[m_addr][i*LW +: LW] = d[i*LW +: LW];
        m_pend = !zz && s && w;
        m_addr = a;
        m_mask = be;
        rd = !zz && s && !w;
        #3;
        chk(tag, {35'd0, dq_drv}, {35'd0, rd && oe});
        if (rd) begin
            chk(tag, dq, model[a]);
            last_rd = model[a];
        end
    endtask

    task automatic t_reset;
        for (int i = 0; i < DP; i++) model[i] = '0;
        repeat (2) @(negedge clk);
        chk("R1 during reset", {35'd0, dq_drv}, 36'd0);
        #1 rst_n = 1'b1;
        @(posedge clk); #3;
        chk("R1 after reset", {35'd0, dq_drv}, 36'd0);
    endtask

    task automatic t_write_read;
        op(1, 1, 4'hF, 6'd3, '0, 0, "R2 write");
        op(0, 0, 4'h0, 6'd0, 36'h123456789, 0, "R8 deselect with data");
        op(1, 0, 4'h0, 6'd3, '0, 0, "R2 readback");
    endtask

    task automatic t_lanes;
        op(1, 1, 4'hF, 6'd9, '0, 0, "R4 full");
        op(1, 1, 4'b0101, 6'd9, 36'hAAAAAAAAA, 0, "R4 partial");
        op(1, 1, 4'b1000, 6'd9, 36'h555555555, 0, "R4 top lane");
        op(1, 0, 4'h0, 6'd9, 36'h0FF0FF0FF, 0, "R4 readback");
    endtask

    task automatic t_b2b;
        op(1, 1, 4'hF, 6'd10, '0, 0, "R5 w0");
        op(1, 1, 4'hF, 6'd11, 36'h111111111, 0, "R5 w1");
        op(1, 1, 4'hF, 6'd12, 36'h222222222, 0, "R5 w2");
        op(1, 0, 4'h0, 6'd10, 36'h333333333, 0, "R5 r0");
        op(1, 0, 4'h0, 6'd11, '0, 0, "R5 r1");
        op(1, 0, 4'h0, 6'd12, '0, 0, "R5 r2");
    endtask

    task automatic t_rar;
        op(1, 1, 4'hF, 6'd20, '0, 0, "R6 write");
        op(1, 0, 4'h0, 6'd20, 36'hBEEFCAFE1, 0, "R6 read on data edge");
    endtask

    task automatic t_timing;
        logic [W-1:0] prev;
        prev = last_rd;
        sel = 1; wr = 0; addr = 6'd11; sleep = 0;
        @(posedge clk); #1;
        chk("R3 before falling edge", dq, prev);
        #2;
        chk("R3 after falling edge", dq, model[11]);
        chk("R3 drive", {35'd0, dq_drv}, 36'd1);
        last_rd = model[11];
    endtask

    task automatic t_oe;
        op(1, 0, 4'h0, 6'd12, '0, 0, "R9 read");
        oe = 1'b0; #0.2;
        chk("R9 oe low", {35'd0, dq_drv}, 36'd0);
        oe = 1'b1; #0.2;
        chk("R9 oe high", {35'd0, dq_drv}, 36'd1);
        oe = 1'b0;
        op(1, 0, 4'h0, 6'd12, '0, 0, "R9 read with oe low");
        oe = 1'b1;
        op(1, 1, 4'hF, 6'd30, '0, 0, "R8 write cycle");
    endtask

    task automatic t_sleep;
        op(1, 1, 4'hF, 6'd40, 36'h777777777, 0, "R10 write before sleep");
        op(1, 1, 4'hF, 6'd40, 36'h9ABCDEF01, 1, "R10 sleep commits");
        op(1, 1, 4'hF, 6'd40, 36'hFFFFFFFFF, 1, "R7 write ignored");
        op(1, 0, 4'h0, 6'd40, '0, 1, "R7 read ignored");
        op(1, 0, 4'h0, 6'd40, 36'h000000000, 0, "R10 resume read");
        op(1, 0, 4'h0, 6'd30, '0, 0, "R10 contents kept");
    endtask

    initial begin
        t_reset;
        t_write_read;
        t_lanes;
        t_b2b;
        t_rar;
        t_timing;
        t_oe;
        t_sleep;
        op(0, 0, 4'h0, 6'd0, '0, 0, "R8 idle");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule